// File: doc/BRIEF.md
# Two-Channel Nibble Framer with Sync Header and Training Preamble

This block takes two one-bit sample streams, A and B, arriving on a slow sample-rate strobe. It gathers each stream into 4-bit groups and queues the groups of each channel in a FIFO of its own. On a faster output strobe it drives one serial line. After reset it first sends an alternating training preamble so that a receiver can find the bit timing. After that it sends 12-bit frames: a fixed sync header, then one group from channel A, then one group from channel B.

Both rates come from clock-enable strobes in one clock domain. A frame starts only when each channel has a complete group queued. Otherwise the line sits low with the valid flag low. Frames follow one another with no gap while data is waiting. A phase register (header, A, B) and a bit index select the source of each bit. The phase also picks which channel FIFO is popped.

Top module: `dual_nibble_framer`

## Requirements
- R1: During and right after a synchronous active-high reset, `line_bit`, `line_valid`, `line_start`, `line_training` and `overflow` are all 0.
- R2: The first TRAIN_BITS (default 32) `out_strobe` pulses after reset drive the alternating pattern 1,0,1,0,... on `line_bit`, with `line_training` high and `line_valid` low. The next pulse drives no training bit.
- R3: A channel's samples are grouped four at a time, counted in `in_strobe` pulses. The k-th sample of a group (k = 0..3) becomes bit k of the group, and it is sent as the k-th bit of that channel's part of the frame.
- R4: A frame is 12 bits, one per `out_strobe`: header bits H0..H3 with Hk = HEADER[k] (default 4'b1010, so 0,1,0,1 on the line), then A0..A3, then B0..B3. `line_valid` is high for all 12 bits.
- R5: `line_start` is high only on the bit that carries H0.
- R6: A frame starts only when both channel FIFOs hold at least one complete group. Otherwise an `out_strobe` drives `line_bit` = 0 and `line_valid` = 0.
- R7: Groups leave each FIFO in arrival order. Frames follow each other with no idle bit while data is queued.
- R8: Each FIFO holds DEPTH groups (default 4). A group completed while its FIFO is full is dropped. `overflow` then goes high and stays high until reset.
- R9: The line outputs change only on a cycle with `out_strobe` high.
- R10: A reset in mid-operation empties both FIFOs, discards any partial group and restarts the training preamble.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_strobe | input | 1 | Sample-rate enable; samples `in_a` and `in_b` |
| in_a | input | 1 | Channel A sample |
| in_b | input | 1 | Channel B sample |
| out_strobe | input | 1 | Output bit-rate enable; advances the line by one bit |
| line_bit | output | 1 | Serial output bit |
| line_valid | output | 1 | High while the line carries a frame bit |
| line_start | output | 1 | High on the H0 bit of each frame |
| line_training | output | 1 | High while the line carries a preamble bit |
| overflow | output | 1 | Sticky: a group was dropped on a full FIFO |

## Verification
A wrong packing index or pop order shows as a wrong bit on the line. The error appears inside the frame that carries the bad group, at the bit position of that sample. A wrong FIFO level shows at the first frame boundary after it goes wrong: either a frame starts without data, or an idle gap appears where a queued frame should follow, or a dropped group turns up later. A faulty phase or index register shows within one frame as a misplaced `line_start` or a header bit that does not match HEADER. A faulty training counter shows as a preamble of the wrong length on the first strobe past TRAIN_BITS.

// File: rtl/framer_pkg.sv
package framer_pkg;

    typedef enum logic [1:0] {
        PH_HDR = 2'd0,
        PH_A   = 2'd1,
        PH_B   = 2'd2
    } phase_e;

    typedef struct packed {
        logic bit_v;
        logic valid;
        logic start;
        logic train;
    } line_t;

    localparam line_t LINE_IDLE = '{bit_v: 1'b0, valid: 1'b0, start: 1'b0, train: 1'b0};

    function automatic phase_e phase_after(input phase_e p);
        case (p)
            PH_HDR:  return PH_A;
            PH_A:    return PH_B;
            default: return PH_HDR;
        endcase
    endfunction

endpackage

// File: rtl/nibble_packer.sv
module nibble_packer #(
    parameter int NIB_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             strobe,
    input  logic             din,
    output logic             push,
    output logic [NIB_W-1:0] nib
);
    localparam int CW = $clog2(NIB_W);

    logic [NIB_W-2:0] held;
    logic [CW-1:0]    cnt;

    assign push = strobe && (cnt == CW'(NIB_W - 1));
    assign nib  = {din, held};

    always_ff @(posedge clk) begin
        if (rst) begin
            held <= '0;
            cnt  <= '0;
        end else if (strobe) begin
            if (cnt == CW'(NIB_W - 1)) begin
                cnt <= '0;
            end else begin
                cnt <= cnt + 1'b1;
                for (int k = 0; k < NIB_W - 1; k++) begin
                    if (cnt == CW'(k)) held[k] <= din;
                end
            end
        end
    end

endmodule

// File: rtl/nibble_fifo.sv
module nibble_fifo #(
    parameter int W     = 4,
    parameter int DEPTH = 4
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       push,
    input  logic [W-1:0]               din,
    input  logic                       pop,
    output logic [W-1:0]               dout,
    output logic [$clog2(DEPTH+1)-1:0] level,
    output logic                       ovf
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int LW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wptr, rptr;
    logic          accept, take;

    assign accept = push && (level != LW'(DEPTH));
    assign take   = pop && (level != '0);
    assign dout   = mem[rptr];

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr  <= '0;
            rptr  <= '0;
            level <= '0;
            ovf   <= 1'b0;
        end else begin
            if (accept) begin
                mem[wptr] <= din;
                wptr      <= (wptr == AW'(DEPTH - 1)) ? '0 : wptr + 1'b1;
            end
            if (take) begin
                rptr <= (rptr == AW'(DEPTH - 1)) ? '0 : rptr + 1'b1;
            end
            if (push && !accept) ovf <= 1'b1;
            level <= level + LW'(accept) - LW'(take);
        end
    end

endmodule

// File: rtl/frame_serializer.sv
module frame_serializer
    import framer_pkg::*;
#(
    parameter int               NIB_W      = 4,
    parameter logic [NIB_W-1:0] HEADER     = 4'b1010,
    parameter int               TRAIN_BITS = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             strobe,
    input  logic [NIB_W-1:0] a_nib,
    input  logic [NIB_W-1:0] b_nib,
    input  logic             a_ready,
    input  logic             b_ready,
    output logic             pop_a,
    output logic             pop_b,
    output line_t            line
);
    localparam int TW = $clog2(TRAIN_BITS + 1);
    localparam int IW = $clog2(NIB_W);

    logic [TW-1:0] tcnt;
    logic          active;
    phase_e        phase, cur_ph;
    logic [IW-1:0] idx, cur_ix;
    logic          preamble, go, last, src;

    assign preamble = (tcnt != TW'(TRAIN_BITS));
    assign go       = strobe && !preamble && (active || (a_ready && b_ready));
    assign cur_ph   = active ? phase : PH_HDR;
    assign cur_ix   = active ? idx : '0;
    assign last     = (cur_ix == IW'(NIB_W - 1));
    assign pop_a    = go && last && (cur_ph == PH_A);
    assign pop_b    = go && last && (cur_ph == PH_B);

    always_comb begin
        case (cur_ph)
            PH_A:    src = a_nib[cur_ix];
            PH_B:    src = b_nib[cur_ix];
            default: src = HEADER[cur_ix];
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tcnt   <= '0;
            active <= 1'b0;
            phase  <= PH_HDR;
            idx    <= '0;
            line   <= LINE_IDLE;
        end else if (strobe) begin
            if (preamble) begin
                line <= '{bit_v: ~tcnt[0], valid: 1'b0, start: 1'b0, train: 1'b1};
                tcnt <= tcnt + 1'b1;
            end else if (go) begin
                line <= '{bit_v: src, valid: 1'b1, start: !active, train: 1'b0};
                if (last) begin
                    idx <= '0;
                    if (cur_ph == PH_B) begin
                        active <= 1'b0;
                        phase  <= PH_HDR;
                    end else begin
                        active <= 1'b1;
                        phase  <= phase_after(cur_ph);
                    end
                end else begin
                    active <= 1'b1;
                    phase  <= cur_ph;
                    idx    <= cur_ix + 1'b1;
                end
            end else begin
                line <= LINE_IDLE;
            end
        end
    end

endmodule

// File: rtl/dual_nibble_framer.sv
module dual_nibble_framer
    import framer_pkg::*;
#(
    parameter int               NIB_W      = 4,
    parameter int               DEPTH      = 4,
    parameter logic [NIB_W-1:0] HEADER     = 4'b1010,
    parameter int               TRAIN_BITS = 32
) (
    input  logic clk,
    input  logic rst,
    input  logic in_strobe,
    input  logic in_a,
    input  logic in_b,
    input  logic out_strobe,
    output logic line_bit,
    output logic line_valid,
    output logic line_start,
    output logic line_training,
    output logic overflow
);
    localparam int LW    = $clog2(DEPTH + 1);
    localparam int N_CH  = 2;
    localparam int CH_A  = 0;
    localparam int CH_B  = 1;

    logic             ch_in   [N_CH];
    logic             ch_push [N_CH];
    logic [NIB_W-1:0] ch_nib  [N_CH];
    logic [NIB_W-1:0] ch_head [N_CH];
    logic             ch_pop  [N_CH];
    logic [LW-1:0]    ch_lvl  [N_CH];
    logic             ch_ovf  [N_CH];
    logic [LW-1:0]    a_level, b_level;
    line_t            line;

    assign ch_in[CH_A] = in_a;
    assign ch_in[CH_B] = in_b;

    for (genvar c = 0; c < N_CH; c++) begin : g_ch
        nibble_packer #(.NIB_W(NIB_W)) u_pack (
            .clk    (clk),
            .rst    (rst),
            .strobe (in_strobe),
            .din    (ch_in[c]),
            .push   (ch_push[c]),
            .nib    (ch_nib[c])
        );
        nibble_fifo #(.W(NIB_W), .DEPTH(DEPTH)) u_fifo (
            .clk   (clk),
            .rst   (rst),
            .push  (ch_push[c]),
            .din   (ch_nib[c]),
            .pop   (ch_pop[c]),
            .dout  (ch_head[c]),
            .level (ch_lvl[c]),
            .ovf   (ch_ovf[c])
        );
    end

    assign a_level = ch_lvl[CH_A];
    assign b_level = ch_lvl[CH_B];

    frame_serializer #(
        .NIB_W      (NIB_W),
        .HEADER     (HEADER),
        .TRAIN_BITS (TRAIN_BITS)
    ) u_ser (
        .clk     (clk),
        .rst     (rst),
        .strobe  (out_strobe),
        .a_nib   (ch_head[CH_A]),
        .b_nib   (ch_head[CH_B]),
        .a_ready (a_level != '0),
        .b_ready (b_level != '0),
        .pop_a   (ch_pop[CH_A]),
        .pop_b   (ch_pop[CH_B]),
        .line    (line)
    );

    assign line_bit      = line.bit_v;
    assign line_valid    = line.valid;
    assign line_start    = line.start;
    assign line_training = line.train;
    assign overflow      = ch_ovf[CH_A] | ch_ovf[CH_B];

endmodule

// File: rtl/framer_checker.sv
module framer_checker #(
    parameter int               NIB_W  = 4,
    parameter int               DEPTH  = 4,
    parameter logic [NIB_W-1:0] HEADER = 4'b1010
) (
    input logic                       clk,
    input logic                       rst,
    input logic                       out_strobe,
    input logic                       line_bit,
    input logic                       line_valid,
    input logic                       line_start,
    input logic                       line_training,
    input logic                       overflow,
    input logic [$clog2(DEPTH+1)-1:0] a_level,
    input logic [$clog2(DEPTH+1)-1:0] b_level
);
    // R1 / R10: one cycle after reset the line is quiet and the flag clear
    a_r10_reset_clears: assert property (@(posedge clk)
        rst |=> (!line_valid && !line_training && !line_start && !line_bit && !overflow));

    // R9: line holds without an output strobe
    a_r9_line_holds: assert property (@(posedge clk) disable iff (rst)
        !out_strobe |=> ($stable(line_bit) && $stable(line_valid) && $stable(line_start)
                         && $stable(line_training)));

    // R5: start marks a frame bit that carries H0
    a_r5_start_on_h0: assert property (@(posedge clk) disable iff (rst)
        line_start |-> (line_valid && line_bit == HEADER[0]));

    // R2: preamble bits are never frame bits
    a_r2_train_not_frame: assert property (@(posedge clk) disable iff (rst)
        line_training |-> !line_valid);

    // R6: a frame begins only with both buffers holding a group
    a_r6_start_needs_data: assert property (@(posedge clk) disable iff (rst)
        $rose(line_start) |-> ($past(a_level) != '0 && $past(b_level) != '0));

    // R8: overflow is sticky and levels stay bounded
    a_r8_overflow_sticky: assert property (@(posedge clk) disable iff (rst)
        overflow |=> overflow);
    a_r8_level_bound: assert property (@(posedge clk) disable iff (rst)
        (a_level <= ($clog2(DEPTH+1))'(DEPTH)) && (b_level <= ($clog2(DEPTH+1))'(DEPTH)));

endmodule

bind dual_nibble_framer framer_checker #(
    .NIB_W  (NIB_W),
    .DEPTH  (DEPTH),
    .HEADER (HEADER)
) u_framer_checker (
    .clk           (clk),
    .rst           (rst),
    .out_strobe    (out_strobe),
    .line_bit      (line_bit),
    .line_valid    (line_valid),
    .line_start    (line_start),
    .line_training (line_training),
    .overflow      (overflow),
    .a_level       (a_level),
    .b_level       (b_level)
);

// File: tb/test_dual_nibble_framer.sv
`timescale 1ns/1ps
module test_dual_nibble_framer;
    localparam logic [3:0] HDR   = 4'b1010;
    localparam int         TRAIN = 32;
    localparam int         DEPTH = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic in_strobe = 1'b0, in_a = 1'b0, in_b = 1'b0, out_strobe = 1'b0;
    logic line_bit, line_valid, line_start, line_training, overflow;
    int   checks = 0, errors = 0;
    bit   done = 1'b0;

    always #2.5 clk = ~clk;

    dual_nibble_framer #(
        .NIB_W(4), .DEPTH(DEPTH), .HEADER(HDR), .TRAIN_BITS(TRAIN)
    ) i_dual_nibble_framer (
        .clk(clk), .rst(rst), .in_strobe(in_strobe), .in_a(in_a), .in_b(in_b),
        .out_strobe(out_strobe), .line_bit(line_bit), .line_valid(line_valid),
        .line_start(line_start), .line_training(line_training), .overflow(overflow)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic strobe_out();
        out_strobe = 1'b1;
        cyc();
        out_strobe = 1'b0;
    endtask

    task automatic push_sample(input logic a, input logic b);
        in_a = a; in_b = b; in_strobe = 1'b1;
        cyc();
        in_strobe = 1'b0;
    endtask

    task automatic push_nibble(input logic [3:0] a, input logic [3:0] b);
        for (int k = 0; k < 4; k++) push_sample(a[k], b[k]);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        cyc(); cyc();
        rst = 1'b0;
    endtask

    task automatic expect_idle(input string req);
        strobe_out();
        chk(req, line_bit, 0);
        chk(req, line_valid, 0);
        chk(req, line_training, 0);
    endtask

    task automatic expect_frame(input logic [3:0] a, input logic [3:0] b);
        for (int k = 0; k < 12; k++) begin
            logic e;
            e = (k < 4) ? HDR[k] : (k < 8) ? a[k-4] : b[k-8];
            strobe_out();
            chk("R4_R3 frame bit", line_bit, e);
            chk("R4 valid", line_valid, 1);
            chk("R5 start", line_start, (k == 0));
        end
    endtask

    task automatic t_reset_state();
        chk("R1 bit", line_bit, 0);
        chk("R1 valid", line_valid, 0);
        chk("R1 start", line_start, 0);
        chk("R1 training", line_training, 0);
        chk("R1 overflow", overflow, 0);
    endtask

    task automatic t_training();
        for (int k = 0; k < TRAIN; k++) begin
            strobe_out();
            chk("R2 pattern", line_bit, (k % 2 == 0));
            chk("R2 training", line_training, 1);
            chk("R2 valid", line_valid, 0);
        end
    endtask

    task automatic t_idle_empty();
        expect_idle("R6 idle when empty");
        expect_idle("R2 preamble ends");
    endtask

    task automatic t_single_frame();
        push_nibble(4'b0110, 4'b1101);
        expect_frame(4'b0110, 4'b1101);
        expect_idle("R6 idle after frame");
    endtask

    task automatic t_hold_without_strobe();
        push_nibble(4'b1111, 4'b0000);
        strobe_out();
        chk("R9 first bit", line_bit, HDR[0]);
        cyc(); cyc(); cyc();
        chk("R9 bit holds", line_bit, HDR[0]);
        chk("R9 start holds", line_start, 1);
        for (int k = 1; k < 12; k++) strobe_out();
        chk("R9 last bit", line_bit, 0);
        expect_idle("R6 idle after held frame");
    endtask

    task automatic t_partial();
        push_sample(1'b1, 1'b0);
        push_sample(1'b0, 1'b1);
        push_sample(1'b0, 1'b1);
        expect_idle("R6 partial group gives idle");
        push_sample(1'b1, 1'b0);
        expect_frame(4'b1001, 4'b0110);
    endtask

    task automatic t_overflow();
        for (int n = 0; n < DEPTH; n++) push_nibble(4'(n + 1), 4'(~(n + 1)));
        chk("R8 no overflow when exactly full", overflow, 0);
        push_nibble(4'hE, 4'h1);
        chk("R8 overflow set", overflow, 1);
        for (int n = 0; n < DEPTH; n++) expect_frame(4'(n + 1), 4'(~(n + 1)));
        expect_idle("R8 dropped group not sent");
        chk("R8 overflow sticky", overflow, 1);
    endtask

    task automatic t_back_to_back();
        push_nibble(4'b0011, 4'b1100);
        push_nibble(4'b0101, 4'b1010);
        expect_frame(4'b0011, 4'b1100);
        expect_frame(4'b0101, 4'b1010);
        expect_idle("R7 idle after queue drains");
    endtask

    task automatic t_reset_restart();
        push_nibble(4'b1011, 4'b0111);
        push_sample(1'b1, 1'b1);
        do_reset();
        chk("R10 overflow cleared", overflow, 0);
        t_training();
        expect_idle("R10 buffers emptied");
        push_nibble(4'b1000, 4'b0001);
        expect_frame(4'b1000, 4'b0001);
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        do_reset();
        t_reset_state();
        t_training();
        t_idle_empty();
        t_single_frame();
        t_hold_without_strobe();
        t_partial();
        t_overflow();
        t_back_to_back();
        t_reset_restart();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule